// File: doc/BRIEF.md
# Receive Link Monitor with Sticky Status Bits

This block decides whether a receive link is usable. It watches two inputs that are synchronous to its clock: a lock flag from the receive clock-recovery loop and a signal-present flag from the line receiver. Losing either of them is a link fault. The live link state falls one clock after a fault is seen. It rises again only after both inputs have been good for a programmable number of consecutive clocks.

Management software reads two status words through a parallel read strobe. The strobe stands in for a serial management access. The basic word carries a link bit that latches low, so a short outage since the last read is never missed. The detailed word carries the live link state and a lock-error bit that latches high. A read returns the sticky values as they were before the access. It then reloads each sticky bit of the word it addressed with the bit's current live value. A fault in the same clock as the read overrides that reload.

Top module: `lnk_monitor`

## Requirements
- R1: After a synchronous reset, `link_up_o` is 0 and both status words read as all zeros while the lock input is high.
- R2: A low `pll_locked_i` sampled on any clock edge sets the lock-error bit (detailed word, bit 1) at that edge. The bit stays 1 after lock returns and stays 1 across reads of the basic word.
- R3: A read of the detailed word (`rd_sel_i` = 1) returns the lock-error bit as it was before the read. If lock is present in the read cycle, the bit is cleared at that edge.
- R4: A fault (`sig_detect_i` low or `pll_locked_i` low) sampled at an edge drives `link_up_o` to 0 at that edge. The same edge clears the sticky link bit of the basic word (bit 0) and the live link bit of the detailed word (bit 0).
- R5: The basic-word link bit (`rd_sel_i` = 0, bit 0) latches low. Once it is 0 it stays 0 until the basic word is read. That read returns 0 and loads the current value of `link_up_o`.
- R6: `link_up_o` rises on the edge at which the N-th consecutive fault-free cycle is sampled, where N = `qual_cnt_i`. A value of 0 is treated as 1.
- R7: A fault in the same cycle as a read overrides the read's reload. Such a read still returns the pre-read value, and the sticky bit takes its fault value.
- R8: `rd_data_o` is registered. It holds the word addressed by a strobe from the edge that samples `rd_en_i` until the next read. Detailed word bit 0 is the live link state. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked_i | input | 1 | Receive clock-recovery lock flag, high when locked |
| sig_detect_i | input | 1 | Line signal present, high when detected |
| qual_cnt_i | input | QUAL_W | Fault-free cycles required before link-up (0 acts as 1) |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_sel_i | input | 1 | Word select: 0 basic, 1 detailed |
| rd_data_o | output | DATA_W | Registered read data |
| link_up_o | output | 1 | Live, qualified link state |

## Verification
Each result is due at a fixed edge:
- A fault sampled at a rising edge shows on `link_up_o` and in the sticky bits right after that edge.
- Link-up appears after the N-th good edge.
- Read data is valid after the edge that samples the strobe.

The bench changes inputs only on falling edges and waits the exact number of rising edges each result needs. It then samples on the next falling edge, checking one cycle early where a rise must not yet have happened. The read-cycle override cases put a fault and a strobe on the same edge, so the returned value and the next read tell which one won.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    SEL_BASIC  = 1'b0,
    SEL_DETAIL = 1'b1
  } reg_sel_e;

  // field positions inside the two status words
  localparam int BASIC_LINK_BIT   = 0;
  localparam int DETAIL_LINK_BIT  = 0;
  localparam int DETAIL_LOCKERR_BIT = 1;
endpackage

// File: rtl/lnk_qualifier.sv
module lnk_qualifier #(
  parameter int QUAL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_i,
  input  logic [QUAL_W-1:0] qual_cnt_i,
  output logic              link_o
);
  localparam int CNT_W = QUAL_W + 1;

  logic [CNT_W-1:0] good_cnt;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] qual_eff;

  always_comb begin
    cnt_next = good_cnt + CNT_W'(1);
    qual_eff = (qual_cnt_i == '0) ? CNT_W'(1) : CNT_W'(qual_cnt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_cnt <= '0;
      link_o   <= 1'b0;
    end else if (fault_i) begin
      good_cnt <= '0;
      link_o   <= 1'b0;
    end else if (!link_o) begin
      good_cnt <= cnt_next;
      if (cnt_next >= qual_eff) link_o <= 1'b1;
    end
  end

  // R4: a sampled fault takes the link down on the next edge
  p_fault_drop_r4: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> !link_o);

  // R6: link can only rise after a fault-free cycle
  p_rise_after_good_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(link_o) |-> $past(!fault_i));
endmodule

// File: rtl/lnk_sticky_bit.sv
module lnk_sticky_bit #(
  parameter bit STICK_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic live_i,
  input  logic clr_i,
  output logic q_o
);
  logic stick_val;

  generate
    if (STICK_HIGH) begin : g_high
      assign stick_val = 1'b1;
    end else begin : g_low
      assign stick_val = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          q_o <= 1'b0;
    else if (event_i) q_o <= stick_val;
    else if (clr_i)   q_o <= live_i;
  end

  // R7: an event in the read cycle beats the read reload
  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    event_i |=> (q_o == stick_val));

  // R2/R5: without event or read the bit holds
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!event_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/lnk_read_port.sv
module lnk_read_port
  import lnk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  reg_sel_e          rd_sel_i,
  input  logic              link_lat_i,
  input  logic              link_live_i,
  input  logic              lockerr_lat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    if (rd_sel_i == SEL_BASIC) begin
      word[BASIC_LINK_BIT] = link_lat_i;
    end else begin
      word[DETAIL_LINK_BIT]    = link_live_i;
      word[DETAIL_LOCKERR_BIT] = lockerr_lat_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= word;
  end

  // R8: data only changes on a read strobe
  p_data_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/lnk_monitor.sv
module lnk_monitor
  import lnk_pkg::*;
#(
  parameter int QUAL_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_locked_i,
  input  logic              sig_detect_i,
  input  logic [QUAL_W-1:0] qual_cnt_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              link_up_o
);
  reg_sel_e sel;
  logic     lock_fault;
  logic     fault;
  logic     rd_basic;
  logic     rd_detail;
  logic     link_lat;
  logic     lockerr_lat;

  assign sel        = reg_sel_e'(rd_sel_i);
  assign lock_fault = !pll_locked_i;
  assign fault      = lock_fault || !sig_detect_i;
  assign rd_basic   = rd_en_i && (sel == SEL_BASIC);
  assign rd_detail  = rd_en_i && (sel == SEL_DETAIL);

  lnk_qualifier #(.QUAL_W(QUAL_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .fault_i    (fault),
    .qual_cnt_i (qual_cnt_i),
    .link_o     (link_up_o)
  );

  // link bit of the basic word: sticks at zero
  lnk_sticky_bit #(.STICK_HIGH(1'b0)) u_link_lat (
    .clk     (clk),
    .rst     (rst),
    .event_i (fault),
    .live_i  (link_up_o),
    .clr_i   (rd_basic),
    .q_o     (link_lat)
  );

  // lock error bit of the detailed word: sticks at one
  lnk_sticky_bit #(.STICK_HIGH(1'b1)) u_lockerr_lat (
    .clk     (clk),
    .rst     (rst),
    .event_i (lock_fault),
    .live_i  (lock_fault),
    .clr_i   (rd_detail),
    .q_o     (lockerr_lat)
  );

  lnk_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk           (clk),
    .rst           (rst),
    .rd_en_i       (rd_en_i),
    .rd_sel_i      (sel),
    .link_lat_i    (link_lat),
    .link_live_i   (link_up_o),
    .lockerr_lat_i (lockerr_lat),
    .rd_data_o     (rd_data_o)
  );

  // R2: loss of lock sets the error bit
  p_lockerr_set_r2: assert property (@(posedge clk) disable iff (rst)
    !pll_locked_i |=> lockerr_lat);

  // R3: a detailed read with lock present clears the error bit
  p_lockerr_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_detail && pll_locked_i) |=> !lockerr_lat);

  // R4: a fault clears the basic link bit
  p_link_lat_clear_r4: assert property (@(posedge clk) disable iff (rst)
    fault |=> !link_lat);
endmodule

// File: tb/lnk_monitor_test.sv
module lnk_monitor_test;
  localparam int QW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pll = 1'b1;
  logic          sig = 1'b0;
  logic [QW-1:0] qual = QW'(5);
  logic          rd_en = 1'b0;
  logic          rd_sel = 1'b0;
  logic [DW-1:0] rd_data;
  logic          link_up;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lnk_monitor #(.QUAL_W(QW), .DATA_W(DW)) uut (
    .clk          (clk),
    .rst          (rst),
    .pll_locked_i (pll),
    .sig_detect_i (sig),
    .qual_cnt_i   (qual),
    .rd_en_i      (rd_en),
    .rd_sel_i     (rd_sel),
    .rd_data_o    (rd_data),
    .link_up_o    (link_up)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // one read access; data is valid after the sampling edge
  task automatic rd(input logic sel, output logic [DW-1:0] d);
    rd_en = 1'b1;
    rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    chk("R1 link after reset", DW'(link_up), DW'(0));
    rd(1'b0, d);
    chk("R1 basic word", d, DW'(0));
    rd(1'b1, d);
    chk("R1 detailed word", d, DW'(0));
  endtask

  task automatic t_qualify();
    logic [DW-1:0] d;
    sig = 1'b1;
    step(4);
    chk("R6 not yet up", DW'(link_up), DW'(0));
    step(1);
    chk("R6 up after N", DW'(link_up), DW'(1));
    rd(1'b1, d);
    chk("R8 detailed live link", d, DW'(1));
    rd(1'b0, d);
    chk("R5 basic still low", d, DW'(0));
    rd(1'b0, d);
    chk("R5 basic reloaded", d, DW'(1));
  endtask

  task automatic t_sigloss();
    logic [DW-1:0] d;
    sig = 1'b0;
    step(1);
    sig = 1'b1;
    chk("R4 link drops", DW'(link_up), DW'(0));
    step(10);
    chk("R6 requalified", DW'(link_up), DW'(1));
    rd(1'b0, d);
    chk("R4 basic cleared by loss", d, DW'(0));
    rd(1'b0, d);
    chk("R5 basic after reread", d, DW'(1));
    rd(1'b1, d);
    chk("R2 no lock error on signal loss", d, DW'(1));
  endtask

  task automatic t_lockloss();
    logic [DW-1:0] d;
    pll = 1'b0;
    step(1);
    pll = 1'b1;
    chk("R4 link drops on lock loss", DW'(link_up), DW'(0));
    step(10);
    rd(1'b0, d);
    chk("R4 basic cleared by lock loss", d, DW'(0));
    rd(1'b1, d);
    chk("R2 lock error held", d, DW'(3));
    rd(1'b1, d);
    chk("R3 lock error cleared", d, DW'(1));
  endtask

  task automatic t_fault_in_read();
    logic [DW-1:0] d;
    pll = 1'b0;
    rd(1'b1, d);
    pll = 1'b1;
    chk("R3 pre-read value returned", d, DW'(1));
    rd(1'b1, d);
    chk("R7 lock fault beats clear", d[1:0], 2'b10);
    rd(1'b1, d);
    chk("R3 cleared after", d[1], 1'b0);
    step(10);
    rd(1'b0, d);
    rd(1'b0, d);
    chk("R5 basic high before test", d, DW'(1));
    sig = 1'b0;
    rd(1'b0, d);
    sig = 1'b1;
    chk("R7 basic pre-read value", d, DW'(1));
    rd(1'b0, d);
    chk("R7 signal fault beats reload", d, DW'(0));
  endtask

  task automatic t_qual_zero();
    qual = '0;
    sig = 1'b0;
    step(1);
    sig = 1'b1;
    chk("R6 down with qual zero", DW'(link_up), DW'(0));
    step(1);
    chk("R6 qual zero acts as one", DW'(link_up), DW'(1));
    qual = QW'(3);
    sig = 1'b0;
    step(1);
    sig = 1'b1;
    step(2);
    chk("R6 qual three early", DW'(link_up), DW'(0));
    step(1);
    chk("R6 qual three", DW'(link_up), DW'(1));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_qualify();
    t_sigloss();
    t_lockloss();
    t_fault_in_read();
    t_qual_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule